// File: doc/BRIEF.md
# Sequential Buffer Address Pointer

This block generates the word address for the clocked side of a 4096 x 16 memory whose other side is accessed at random. A 12-bit pointer steps forward by one on each clock edge where the active-low count enable is sampled low. Software-visible registers elsewhere supply two start addresses and two end addresses. The pointer can be sent to either start address with a strobe, or loaded from a value on the data bus. A bus load takes effect one edge after it is sampled.

Two active-low end-of-buffer flags report when counting has carried the pointer onto each end address. A flag stays set until it is cleared through a control-register write, or until reset. A third output reports protocol misuse of the start strobes.

The pointer is a control quantity, not a data stream, so every pin is a plain level or strobe. There is no valid/ready handshake and no back-pressure: the block acts on every sampled edge.

Top module: `seqbuf_addr_seq`

## Requirements
- R1: While `rst_n` is low, the following hold at once, without waiting for a clock: `ptr_o` is 0, `eob1_n` and `eob2_n` are 1, `proto_err_o` is 0, and any captured bus load is discarded.
- R2: On an edge with `cnt_en_n` low and no load or start event applying, `ptr_o` becomes `ptr_o + 1`, and 4095 is followed by 0.
- R3: On an edge with `cnt_en_n` high and no load or start event applying, `ptr_o` keeps its value.
- R4: An edge that samples `ld_n` low captures `ld_val` into a data-in register. `ptr_o` takes the captured value on the next edge. On the capture edge itself, `ptr_o` follows the other inputs.
- R5: An edge that samples `strt1_n` low loads `start1_addr`, and one that samples `strt2_n` low loads `start2_addr`. If both are low, start 1 wins.
- R6: Priority on any edge, highest first: a pending bus load, then a start strobe, then counting.
- R7: `eobN_n` goes low on an edge where counting moves `ptr_o` onto `endN_addr`. A load or start that lands on that address does not set it. The two flags use separate end addresses and do not affect each other.
- R8: Once low, a flag stays low while the pointer moves on, until it is cleared.
- R9: A write with `ctrl_wr_en` high, `ctrl_wr_addr` = 3'b101 and `ctrl_wr_data[0]` = 0 clears `eob1_n` to 1. `ctrl_wr_data[1]` = 0 clears `eob2_n` in the same way. A data bit of 1, or any other address, has no effect. If a flag is set and cleared on the same edge, the set wins.
- R10: `proto_err_o` is 1 for the cycle after an edge that samples a start strobe low while `ld_n` is low or a bus load is pending. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en_n | input | 1 | Active-low count enable |
| ld_n | input | 1 | Active-low bus-load strobe |
| strt1_n | input | 1 | Active-low jump to start address 1 |
| strt2_n | input | 1 | Active-low jump to start address 2 |
| ld_val | input | 12 | Address value captured by a bus load |
| start1_addr | input | 12 | Start address of buffer 1 |
| start2_addr | input | 12 | Start address of buffer 2 |
| end1_addr | input | 12 | End address of buffer 1 |
| end2_addr | input | 12 | End address of buffer 2 |
| ctrl_wr_en | input | 1 | Control-register write strobe |
| ctrl_wr_addr | input | 3 | Control-register write address |
| ctrl_wr_data | input | 2 | Flag-clear bits (0 clears) |
| ptr_o | output | 12 | Current pointer |
| eob1_n | output | 1 | Active-low end-of-buffer flag 1 |
| eob2_n | output | 1 | Active-low end-of-buffer flag 2 |
| proto_err_o | output | 1 | Start-strobe protocol violation |

## Verification
The bench targets the one-edge delay of a bus load while counting is also enabled. A design that applied the load at once, or let the count overwrite it, would show the wrong pointer on the capture edge or on the edge after it. It also targets wrap from 4095 to 0, loads and starts that land exactly on an end address, and a flag set and cleared on the same edge. These catch flags raised by jumps rather than counts, and edges where the set is lost to the clear. A start strobe during a pending load checks both the pointer priority and the violation output. A reset applied mid-cycle shows whether clearing really happens without a clock.

// File: rtl/seqbuf_pkg.sv
package seqbuf_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned NBUF     = 2;
  localparam int unsigned CTRL_AW  = 3;
  localparam logic [CTRL_AW-1:0] CTRL_FLAG_ADDR = 3'b101;

  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_INC,
    SRC_LOAD,
    SRC_START1,
    SRC_START2
  } ptr_src_e;
endpackage

// File: rtl/seqbuf_ld_stage.sv
module seqbuf_ld_stage #(
  parameter int unsigned AW = seqbuf_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic [AW-1:0] ld_val,
  output logic [AW-1:0] ld_data,
  output logic          ld_pend
);
  // data-in register: holds the bus value for one edge before it reaches the pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_data <= '0;
      ld_pend <= 1'b0;
    end else begin
      ld_pend <= !ld_n;
      if (!ld_n) ld_data <= ld_val;
    end
  end
endmodule

// File: rtl/seqbuf_ptr_core.sv
module seqbuf_ptr_core #(
  parameter int unsigned AW = seqbuf_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_pend,
  input  logic [AW-1:0] ld_data,
  input  logic          strt1_n,
  input  logic          strt2_n,
  input  logic          cnt_en_n,
  input  logic [AW-1:0] start1_addr,
  input  logic [AW-1:0] start2_addr,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] ptr_nxt,
  output logic          inc_evt
);
  import seqbuf_pkg::*;

  ptr_src_e src;

  always_comb begin
    if (ld_pend)        src = SRC_LOAD;
    else if (!strt1_n)  src = SRC_START1;
    else if (!strt2_n)  src = SRC_START2;
    else if (!cnt_en_n) src = SRC_INC;
    else                src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_LOAD:   ptr_nxt = ld_data;
      SRC_START1: ptr_nxt = start1_addr;
      SRC_START2: ptr_nxt = start2_addr;
      SRC_INC:    ptr_nxt = ptr_q + AW'(1);
      default:    ptr_nxt = ptr_q;
    endcase
  end

  assign inc_evt = (src == SRC_INC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nxt;
  end
endmodule

// File: rtl/seqbuf_eob_flag.sv
module seqbuf_eob_flag #(
  parameter int unsigned AW = seqbuf_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_evt,
  input  logic [AW-1:0] ptr_nxt,
  input  logic [AW-1:0] end_addr,
  input  logic          clr,
  output logic          flag_n
);
  logic hit;
  assign hit = inc_evt && (ptr_nxt == end_addr);

  // sticky; a set on the same edge as a clear takes precedence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_n <= 1'b1;
    else if (hit) flag_n <= 1'b0;
    else if (clr) flag_n <= 1'b1;
  end
endmodule

// File: rtl/seqbuf_proto_guard.sv
module seqbuf_proto_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_n,
  input  logic ld_pend,
  input  logic strt1_n,
  input  logic strt2_n,
  output logic proto_err
);
  logic strt_any, ld_window;
  assign strt_any  = !strt1_n || !strt2_n;
  assign ld_window = !ld_n || ld_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= strt_any && ld_window;
  end
endmodule

// File: rtl/seqbuf_addr_seq.sv
module seqbuf_addr_seq #(
  parameter int unsigned AW  = seqbuf_pkg::ADDR_W,
  parameter int unsigned CAW = seqbuf_pkg::CTRL_AW
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cnt_en_n,
  input  logic                           ld_n,
  input  logic                           strt1_n,
  input  logic                           strt2_n,
  input  logic [AW-1:0]                  ld_val,
  input  logic [AW-1:0]                  start1_addr,
  input  logic [AW-1:0]                  start2_addr,
  input  logic [AW-1:0]                  end1_addr,
  input  logic [AW-1:0]                  end2_addr,
  input  logic                           ctrl_wr_en,
  input  logic [CAW-1:0]                 ctrl_wr_addr,
  input  logic [seqbuf_pkg::NBUF-1:0]    ctrl_wr_data,
  output logic [AW-1:0]                  ptr_o,
  output logic                           eob1_n,
  output logic                           eob2_n,
  output logic                           proto_err_o
);
  localparam int unsigned NB = seqbuf_pkg::NBUF;
  localparam logic [CAW-1:0] FLAG_ADDR = CAW'(seqbuf_pkg::CTRL_FLAG_ADDR);

  logic [AW-1:0] ld_data;
  logic          ld_pend;
  logic [AW-1:0] ptr_nxt;
  logic          inc_evt;
  logic [AW-1:0] end_arr [NB];
  logic [NB-1:0] clr_req;
  logic [NB-1:0] eob_n;
  logic          ctrl_hit;

  seqbuf_ld_stage #(.AW(AW)) u_ld (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_n    (ld_n),
    .ld_val  (ld_val),
    .ld_data (ld_data),
    .ld_pend (ld_pend)
  );

  seqbuf_ptr_core #(.AW(AW)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_pend     (ld_pend),
    .ld_data     (ld_data),
    .strt1_n     (strt1_n),
    .strt2_n     (strt2_n),
    .cnt_en_n    (cnt_en_n),
    .start1_addr (start1_addr),
    .start2_addr (start2_addr),
    .ptr_q       (ptr_o),
    .ptr_nxt     (ptr_nxt),
    .inc_evt     (inc_evt)
  );

  assign end_arr[0] = end1_addr;
  assign end_arr[1] = end2_addr;
  assign ctrl_hit   = ctrl_wr_en && (ctrl_wr_addr == FLAG_ADDR);

  for (genvar g = 0; g < NB; g++) begin : g_flag
    assign clr_req[g] = ctrl_hit && !ctrl_wr_data[g];
    seqbuf_eob_flag #(.AW(AW)) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_evt  (inc_evt),
      .ptr_nxt  (ptr_nxt),
      .end_addr (end_arr[g]),
      .clr      (clr_req[g]),
      .flag_n   (eob_n[g])
    );
  end

  assign eob1_n = eob_n[0];
  assign eob2_n = eob_n[1];

  seqbuf_proto_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_n      (ld_n),
    .ld_pend   (ld_pend),
    .strt1_n   (strt1_n),
    .strt2_n   (strt2_n),
    .proto_err (proto_err_o)
  );
endmodule

// File: rtl/seqbuf_addr_seq_chk.sv
module seqbuf_addr_seq_chk #(
  parameter int unsigned AW  = 12,
  parameter int unsigned CAW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cnt_en_n,
  input logic           ld_n,
  input logic           strt1_n,
  input logic           strt2_n,
  input logic [AW-1:0]  ld_val,
  input logic [AW-1:0]  start1_addr,
  input logic [AW-1:0]  end1_addr,
  input logic           ctrl_wr_en,
  input logic [CAW-1:0] ctrl_wr_addr,
  input logic [1:0]     ctrl_wr_data,
  input logic [AW-1:0]  ptr_o,
  input logic           eob1_n,
  input logic           proto_err_o,
  input logic           ld_pend
);
  logic quiet, clr1;
  assign quiet = !ld_pend && strt1_n && strt2_n;
  assign clr1  = ctrl_wr_en && (ctrl_wr_addr == CAW'(5)) && !ctrl_wr_data[0];

  // R4
  load_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> ##1 (ptr_o == $past(ld_val, 2)));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !cnt_en_n) |=> (ptr_o == AW'($past(ptr_o) + AW'(1))));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && cnt_en_n) |=> $stable(ptr_o));

  // R5
  start1_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_pend && !strt1_n) |=> (ptr_o == $past(start1_addr)));

  // R7
  flag1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !cnt_en_n && (AW'(ptr_o + AW'(1)) == end1_addr)) |=> !eob1_n);

  // R8
  flag1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eob1_n && !clr1) |=> !eob1_n);

  // R9
  flag1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr1 && cnt_en_n) |=> eob1_n);

  // R10
  proto_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strt1_n || !strt2_n) && (!ld_n || ld_pend)) |=> proto_err_o);
endmodule

bind seqbuf_addr_seq seqbuf_addr_seq_chk #(.AW(AW), .CAW(CAW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_en_n     (cnt_en_n),
  .ld_n         (ld_n),
  .strt1_n      (strt1_n),
  .strt2_n      (strt2_n),
  .ld_val       (ld_val),
  .start1_addr  (start1_addr),
  .end1_addr    (end1_addr),
  .ctrl_wr_en   (ctrl_wr_en),
  .ctrl_wr_addr (ctrl_wr_addr),
  .ctrl_wr_data (ctrl_wr_data),
  .ptr_o        (ptr_o),
  .eob1_n       (eob1_n),
  .proto_err_o  (proto_err_o),
  .ld_pend      (ld_pend)
);

// File: tb/seqbuf_addr_seq_test.sv
module seqbuf_addr_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, cnt_en_n, ld_n, strt1_n, strt2_n, ctrl_wr_en;
  logic [11:0] ld_val, start1_addr, start2_addr, end1_addr, end2_addr, ptr_o;
  logic [2:0]  ctrl_wr_addr;
  logic [1:0]  ctrl_wr_data;
  logic        eob1_n, eob2_n, proto_err_o;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seqbuf_addr_seq uut (.*);

  // behavioural reference model
  int m_ptr;
  bit m_f1, m_f2, m_perr, had, s1, s2, inc;
  int m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_f1 = 1; m_f2 = 1; m_perr = 0; m_q.delete();
    end else begin
      had = (m_q.size() > 0);
      s1 = !strt1_n; s2 = !strt2_n; inc = 0;
      if (had) m_ptr = m_q.pop_front();
      else if (s1) m_ptr = start1_addr;
      else if (s2) m_ptr = start2_addr;
      else if (!cnt_en_n) begin m_ptr = (m_ptr + 1) % 4096; inc = 1; end
      if (inc && m_ptr == end1_addr) m_f1 = 0;
      else if (ctrl_wr_en && ctrl_wr_addr == 3'd5 && !ctrl_wr_data[0]) m_f1 = 1;
      if (inc && m_ptr == end2_addr) m_f2 = 0;
      else if (ctrl_wr_en && ctrl_wr_addr == 3'd5 && !ctrl_wr_data[1]) m_f2 = 1;
      m_perr = (s1 || s2) && (!ld_n || had);
      if (!ld_n) m_q.push_back(int'(ld_val));
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check({cur_req, " model ptr"},  int'(ptr_o), m_ptr);
    check({cur_req, " model eob1"}, int'(eob1_n), int'(m_f1));
    check({cur_req, " model eob2"}, int'(eob2_n), int'(m_f2));
    check({cur_req, " model perr"}, int'(proto_err_o), int'(m_perr));
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr_ctrl(logic [2:0] a, logic [1:0] d);
    ctrl_wr_en = 1; ctrl_wr_addr = a; ctrl_wr_data = d;
    tick();
    ctrl_wr_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cnt_en_n = 1; ld_n = 1; strt1_n = 1; strt2_n = 1;
    ld_val = 0; start1_addr = 5; start2_addr = 18; end1_addr = 10; end2_addr = 20;
    ctrl_wr_en = 0; ctrl_wr_addr = 0; ctrl_wr_data = 2'b11;
    tick(3);
    check("R1 ptr", int'(ptr_o), 0);
    check("R1 eob1", int'(eob1_n), 1);
    check("R1 eob2", int'(eob2_n), 1);
    check("R1 perr", int'(proto_err_o), 0);
    rst_n = 1; tick();

    cur_req = "R3"; tick(3);
    check("R3 hold", int'(ptr_o), 0);

    cur_req = "R2"; cnt_en_n = 0; tick(3); cnt_en_n = 1;
    check("R2 count", int'(ptr_o), 3);

    cur_req = "R5"; strt1_n = 0; tick(); strt1_n = 1;
    check("R5 start1", int'(ptr_o), 5);

    cur_req = "R7"; cnt_en_n = 0; tick(5);
    check("R7 ptr at end1", int'(ptr_o), 10);
    check("R7 eob1 set", int'(eob1_n), 0);
    check("R7 eob2 independent", int'(eob2_n), 1);
    cur_req = "R8"; tick(2); cnt_en_n = 1;
    check("R8 eob1 sticky", int'(eob1_n), 0);

    cur_req = "R9";
    wr_ctrl(3'b100, 2'b00);
    check("R9 wrong address ignored", int'(eob1_n), 0);
    wr_ctrl(3'b101, 2'b01);
    check("R9 bit0=1 ignored", int'(eob1_n), 0);
    wr_ctrl(3'b101, 2'b10);
    check("R9 bit0=0 clears", int'(eob1_n), 1);

    cur_req = "R5"; strt2_n = 0; tick();
    check("R5 start2", int'(ptr_o), 18);
    strt1_n = 0; tick(); strt1_n = 1; strt2_n = 1;
    check("R5 start1 wins", int'(ptr_o), 5);

    cur_req = "R4"; ld_val = 10; ld_n = 0; tick(); ld_n = 1;
    check("R4 not yet loaded", int'(ptr_o), 5);
    tick();
    check("R4 loaded", int'(ptr_o), 10);
    check("R7 load onto end no flag", int'(eob1_n), 1);

    cur_req = "R7"; strt2_n = 0; tick(); strt2_n = 1;
    cnt_en_n = 0; tick(2);
    check("R7 eob2 set", int'(eob2_n), 0);
    check("R7 eob1 untouched", int'(eob1_n), 1);

    cur_req = "R6"; ld_val = 100; ld_n = 0; tick(); ld_n = 1;
    check("R6 count on capture edge", int'(ptr_o), 21);
    tick(); cnt_en_n = 1;
    check("R6 load beats count", int'(ptr_o), 100);

    cur_req = "R10"; ld_val = 200; ld_n = 0; tick(); ld_n = 1;
    strt1_n = 0; tick(); strt1_n = 1;
    check("R6 load beats start", int'(ptr_o), 200);
    check("R10 start in pending cycle", int'(proto_err_o), 1);
    tick();
    check("R10 clears", int'(proto_err_o), 0);
    ld_val = 300; ld_n = 0; strt2_n = 0; tick(); ld_n = 1; strt2_n = 1;
    check("R10 start with load", int'(proto_err_o), 1);
    check("R6 start applied", int'(ptr_o), 18);
    tick();
    check("R4 load after start", int'(ptr_o), 300);

    cur_req = "R2"; ld_val = 4094; ld_n = 0; tick(); ld_n = 1; tick();
    cnt_en_n = 0; tick(2); cnt_en_n = 1;
    check("R2 wrap", int'(ptr_o), 0);

    cur_req = "R9"; wr_ctrl(3'b101, 2'b00);
    check("R9 both cleared", int'(eob2_n), 1);
    end1_addr = 1; cnt_en_n = 0;
    wr_ctrl(3'b101, 2'b00); cnt_en_n = 1;
    check("R9 set beats clear", int'(eob1_n), 0);

    cur_req = "R1";
    #(CLK_PERIOD/4) rst_n = 0;
    #1;
    check("R1 async ptr", int'(ptr_o), 0);
    check("R1 async eob1", int'(eob1_n), 1);
    @(negedge clk); rst_n = 1; tick();

    cur_req = "R6";
    end1_addr = 12'd7; end2_addr = 12'd12;
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom);
      cnt_en_n = r[0] & r[1];
      ld_n     = ~(r[2] & r[3] & r[4]);
      strt1_n  = ~(r[5] & r[6] & r[7]);
      strt2_n  = ~(r[8] & r[9] & r[10]);
      ld_val   = 12'(r[15:12]);
      ctrl_wr_en   = r[16] & r[17];
      ctrl_wr_addr = {1'b1, r[18], 1'b1};
      ctrl_wr_data = r[20:19];
      start1_addr  = 12'(r[23:21]);
      start2_addr  = 12'(r[26:24]) + 12'd4;
      tick();
    end
    cnt_en_n = 1; ld_n = 1; strt1_n = 1; strt2_n = 1; ctrl_wr_en = 0;
    tick(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule